// File: doc/BRIEF.md
# Random Number Generator Control and Status Block

This block is the register front end of a random number generator. A host reads and writes six 32-bit word registers through a simple port that takes one access per cycle. The registers are an identity word, a command word, a control word, a status word, an error word and an output queue. From the command word the host starts a self-test or a seed generation. Each operation runs for a fixed number of cycles. When it ends, the block raises a done flag, and the interrupt line follows that flag unless the host masks it. After a successful seed, a deterministic stub generator (a 32-bit Galois LFSR) fills a 16-word output queue at one word per cycle. The host drains the queue one word per read.

An error input for test use makes the operation that is finishing report a statistical failure. While that failure is latched, the queue stops refilling. A clear-interrupt command cannot remove the interrupt in this state; only the clear-error command can. When the host enables it, the block starts a fresh seed by itself after a set number of words have been served.

The sequencer has three states: `ST_IDLE`, `ST_SELFTEST` and `ST_SEEDING`. The transitions are:
- `ST_IDLE` to `ST_SELFTEST` on a self-test command. This has priority.
- `ST_IDLE` to `ST_SEEDING` on a seed command or a pending automatic reseed.
- `ST_SELFTEST` to `ST_IDLE` when the operation counter expires. This asserts the self-test finish strobe.
- `ST_SEEDING` to `ST_IDLE` when the operation counter expires. This asserts the seed finish strobe.
- Each busy state holds while its counter runs. Commands that arrive while the sequencer is busy are dropped.

Top module: `rng_ctl`

## Requirements
- R1: After reset the status word reads 0, the error word reads 0, control reads 0x60 (both interrupt masks set), the queue level is 0 and `irq` is low.
- R2: Word addresses are 0x00 identity, 0x04 command, 0x08 control, 0x0C status, 0x10 error and 0x14 queue. The identity word reads {DEV_TYPE[3:0] in bits 31:28, zeros, REV_MAJOR in 15:8, REV_MINOR in 7:0}. The command word always reads 0.
- R3: Writing command bit 0 starts a self-test when the sequencer is idle. Status bit 4 sets OP_CYCLES cycles after the write. Any command that starts an operation while the sequencer is busy is ignored.
- R4: Writing command bit 1 starts a seed generation. Status bit 5 sets when it completes. The queue then fills to 16 words at one word per cycle while no error is latched.
- R5: A read of address 0x14 pops the head word and lowers the level in status bits 12:8 by one. A read of an empty queue returns 0 and leaves the level at 0.
- R6: Every word popped from the queue is nonzero, and two words popped in a row differ.
- R7: `irq` = ((status bit 4 OR bit 5) AND NOT control bit 5) OR (status bit 16 AND NOT control bit 6).
- R8: When the error input is high as an operation completes, status bit 16 sets and the error word reads 0x8. While the error is latched, the queue level never rises.
- R9: Command bit 4 clears status bits 4 and 5 only when status bit 16 is clear. With an error latched it has no effect.
- R10: Command bit 5 clears status bits 16, 5 and 4 and the error word. After that, refilling resumes.
- R11: With control bit 4 set, the RESEED_WORDS-th word popped while it is set starts a seed by itself, and status bit 5 sets at its end. With control bit 4 clear, pops never start a seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the current address |
| rd_en | input | 1 | Read strobe; a read of the queue pops it |
| addr | input | 5 | Byte address; only word-aligned addresses decode |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the current address, combinational |
| irq | output | 1 | Combined done/error interrupt |
| inject_err | input | 1 | Test input: the operation that is finishing reports a statistical error |

## Verification
The bench goes after the interplay of the interrupt clears. If the clear-interrupt command were not gated by the latched error, status bit 4 would drop while bit 16 stays set. If the clear-error command missed the done bits, `irq` would remain high once the masks are open. It drains the queue past empty with the refill halted by an error, using a random count. This exposes a level that wraps below zero, or an empty read that returns stale data. A seed command issued during a self-test shows whether a busy sequencer wrongly accepts a new command, because status bit 5 would then appear. The automatic reseed is probed one word before and at the threshold, and again with the enable clear. This catches an off-by-one in the served-word count and a reseed that ignores the enable.

// File: rtl/rng_ctl_pkg.sv
package rng_ctl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_SELFTEST = 2'd1,
        ST_SEEDING  = 2'd2
    } op_state_e;

    localparam logic [2:0] WA_IDENT  = 3'd0;
    localparam logic [2:0] WA_CMD    = 3'd1;
    localparam logic [2:0] WA_CTRL   = 3'd2;
    localparam logic [2:0] WA_STATUS = 3'd3;
    localparam logic [2:0] WA_ERR    = 3'd4;
    localparam logic [2:0] WA_QUEUE  = 3'd5;

    localparam int CB_TEST    = 0;
    localparam int CB_SEED    = 1;
    localparam int CB_CLR_INT = 4;
    localparam int CB_CLR_ERR = 5;

    localparam int KB_AUTO      = 4;
    localparam int KB_MASK_DONE = 5;
    localparam int KB_MASK_ERR  = 6;

    localparam int SB_TEST_DONE = 4;
    localparam int SB_SEED_DONE = 5;
    localparam int SB_LEVEL     = 8;
    localparam int SB_ERR       = 16;

    localparam logic [31:0] ERR_STAT_FAIL = 32'h0000_0008;
endpackage

// File: rtl/rng_ctl_seq.sv
module rng_ctl_seq
    import rng_ctl_pkg::*;
#(
    parameter int OP_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_test,
    input  logic start_seed,
    output logic idle,
    output logic fin_test,
    output logic fin_seed
);
    localparam int CW = $clog2(OP_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(OP_CYCLES - 1);

    op_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_test) begin
                    state_d = ST_SELFTEST;
                    cnt_d   = LOAD;
                end else if (start_seed) begin
                    state_d = ST_SEEDING;
                    cnt_d   = LOAD;
                end
            end
            ST_SELFTEST, ST_SEEDING: begin
                if (cnt_q == '0) state_d = ST_IDLE;
                else             cnt_d   = cnt_q - 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        idle     = 1'b0;
        fin_test = 1'b0;
        fin_seed = 1'b0;
        unique case (state_q)
            ST_IDLE:     idle     = 1'b1;
            ST_SELFTEST: fin_test = (cnt_q == '0);
            ST_SEEDING:  fin_seed = (cnt_q == '0);
            default:     idle     = 1'b0;
        endcase
    end

    // R3: a running operation holds its state until its counter expires
    assert_busy_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && cnt_q != '0) |=> state_q == $past(state_q));
    // R3: finishing always returns to idle
    assert_finish_idles_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_test || fin_seed) |=> state_q == ST_IDLE);
endmodule

// File: rtl/rng_ctl_lfsr.sv
module rng_ctl_lfsr #(
    parameter int          WIDTH = 32,
    parameter logic [31:0] TAPS  = 32'h8020_0003,
    parameter logic [31:0] INIT  = 32'h1D87_2B41
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [WIDTH-1:0] value
);
    logic [WIDTH-1:0] st_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    st_q <= INIT[WIDTH-1:0];
        else if (step) st_q <= {1'b0, st_q[WIDTH-1:1]} ^ (st_q[0] ? TAPS[WIDTH-1:0] : '0);
    end

    assign value = st_q;

    // R6: the generator never reaches the all-zero lock-up state
    assert_lfsr_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q != '0);
endmodule

// File: rtl/rng_ctl_fifo.sv
module rng_ctl_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             refill_en,
    input  logic             pop_req,
    input  logic [WIDTH-1:0] gen_word,
    output logic             push,
    output logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [$clog2(DEPTH+1)-1:0] level
);
    localparam int PW = $clog2(DEPTH);
    localparam int LW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    rd_ptr, wr_ptr;
    logic [LW-1:0]    lvl_q;

    assign push  = refill_en && (lvl_q < LW'(DEPTH));
    assign pop   = pop_req && (lvl_q != '0);
    assign head  = (lvl_q != '0) ? mem[rd_ptr] : '0;
    assign level = lvl_q;

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= gen_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            lvl_q  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            unique case ({push, pop})
                2'b10:   lvl_q <= lvl_q + 1'b1;
                2'b01:   lvl_q <= lvl_q - 1'b1;
                default: lvl_q <= lvl_q;
            endcase
        end
    end

    // R5: level never exceeds the queue depth
    assert_level_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_q <= LW'(DEPTH));
    // R5: reading an empty queue without a refill leaves it empty
    assert_empty_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && lvl_q == '0 && !refill_en) |=> lvl_q == '0);
endmodule

// File: rtl/rng_ctl.sv
module rng_ctl
    import rng_ctl_pkg::*;
#(
    parameter int          OP_CYCLES    = 64,
    parameter int          DEPTH        = 16,
    parameter int          RESEED_WORDS = 1 << 20,
    parameter logic [3:0]  DEV_TYPE     = 4'd2,
    parameter logic [7:0]  REV_MAJOR    = 8'd1,
    parameter logic [7:0]  REV_MINOR    = 8'd3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [4:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        irq,
    input  logic        inject_err
);
    localparam int LW = $clog2(DEPTH + 1);
    localparam int RW = $clog2(RESEED_WORDS + 1);

    logic          aligned;
    logic [2:0]    widx;
    logic          cmd_wr, ctrl_wr, q_rd;
    logic          go_test, go_seed, clr_int, clr_err;
    logic          seq_idle, fin_test, fin_seed, op_fin;
    logic          done_test_q, done_seed_q, err_q, seeded_q, auto_pend_q;
    logic          auto_en_q, mask_done_q, mask_err_q;
    logic [RW-1:0] served_q;
    logic          refill_en, push, pop;
    logic [31:0]   gen_word, head;
    logic [LW-1:0] level;
    logic          unused_wdata;

    assign unused_wdata = ^{wdata[31:7], wdata[3:2]};
    assign aligned  = (addr[1:0] == 2'b00);
    assign widx     = addr[4:2];
    assign cmd_wr   = wr_en && aligned && widx == WA_CMD;
    assign ctrl_wr  = wr_en && aligned && widx == WA_CTRL;
    assign q_rd     = rd_en && aligned && widx == WA_QUEUE;
    assign go_test  = cmd_wr && wdata[CB_TEST];
    assign go_seed  = (cmd_wr && wdata[CB_SEED]) || auto_pend_q;
    assign clr_int  = cmd_wr && wdata[CB_CLR_INT];
    assign clr_err  = cmd_wr && wdata[CB_CLR_ERR];
    assign op_fin   = fin_test || fin_seed;
    assign refill_en = seeded_q && !err_q && seq_idle;

    rng_ctl_seq #(.OP_CYCLES(OP_CYCLES)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start_test(go_test), .start_seed(go_seed),
        .idle(seq_idle), .fin_test(fin_test), .fin_seed(fin_seed)
    );

    rng_ctl_lfsr #(.WIDTH(32)) u_gen (
        .clk(clk), .rst_n(rst_n), .step(push), .value(gen_word)
    );

    rng_ctl_fifo #(.DEPTH(DEPTH), .WIDTH(32)) u_queue (
        .clk(clk), .rst_n(rst_n), .refill_en(refill_en), .pop_req(q_rd),
        .gen_word(gen_word), .push(push), .pop(pop), .head(head), .level(level)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            auto_en_q   <= 1'b0;
            mask_done_q <= 1'b1;
            mask_err_q  <= 1'b1;
        end else if (ctrl_wr) begin
            auto_en_q   <= wdata[KB_AUTO];
            mask_done_q <= wdata[KB_MASK_DONE];
            mask_err_q  <= wdata[KB_MASK_ERR];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_test_q <= 1'b0;
            done_seed_q <= 1'b0;
            err_q       <= 1'b0;
            seeded_q    <= 1'b0;
        end else begin
            if (clr_err) begin
                done_test_q <= 1'b0;
                done_seed_q <= 1'b0;
                err_q       <= 1'b0;
            end else if (clr_int && !err_q) begin
                done_test_q <= 1'b0;
                done_seed_q <= 1'b0;
            end
            if (fin_test) done_test_q <= 1'b1;
            if (fin_seed) done_seed_q <= 1'b1;
            if (op_fin && inject_err) err_q <= 1'b1;
            if (fin_seed && !inject_err) seeded_q <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            served_q    <= '0;
            auto_pend_q <= 1'b0;
        end else begin
            if (auto_pend_q && seq_idle) auto_pend_q <= 1'b0;
            if (pop && auto_en_q) begin
                if (served_q == RW'(RESEED_WORDS - 1)) begin
                    served_q    <= '0;
                    auto_pend_q <= 1'b1;
                end else begin
                    served_q <= served_q + 1'b1;
                end
            end
        end
    end

    assign irq = ((done_test_q || done_seed_q) && !mask_done_q) || (err_q && !mask_err_q);

    always_comb begin
        rdata = '0;
        if (aligned) begin
            unique case (widx)
                WA_IDENT:  rdata = {DEV_TYPE, 12'd0, REV_MAJOR, REV_MINOR};
                WA_CTRL:   rdata[KB_MASK_ERR:KB_AUTO] = {mask_err_q, mask_done_q, auto_en_q};
                WA_STATUS: begin
                    rdata[SB_TEST_DONE]        = done_test_q;
                    rdata[SB_SEED_DONE]        = done_seed_q;
                    rdata[SB_LEVEL +: LW]      = level;
                    rdata[SB_ERR]              = err_q;
                end
                WA_ERR:    rdata = err_q ? ERR_STAT_FAIL : '0;
                WA_QUEUE:  rdata = head;
                default:   rdata = '0;
            endcase
        end
    end

    // R7: an unmasked latched error always drives the interrupt
    assert_err_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !mask_err_q) |-> irq);
    // R8: the queue level never rises while an error is latched
    assert_no_refill_on_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> level <= $past(level));
    // R9: clear-interrupt cannot drop done flags while an error is latched
    assert_clrint_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_int && !clr_err && err_q) |=>
            (done_test_q == $past(done_test_q) && done_seed_q == $past(done_seed_q)));
    // R10: clear-error wipes the error unless a failing operation ends at once
    assert_clrerr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_err && !(op_fin && inject_err)) |=> !err_q);
endmodule

// File: tb/rng_ctl_bench.sv
`timescale 1ns/1ps
module rng_ctl_bench;
    localparam int OPC = 6;
    localparam int RSW = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0, inject_err = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    rng_ctl #(.OP_CYCLES(OPC), .DEPTH(16), .RESEED_WORDS(RSW),
              .DEV_TYPE(4'd2), .REV_MAJOR(8'd1), .REV_MINOR(8'd3)) u_rng_ctl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq), .inject_err(inject_err)
    );

    function automatic logic exp_irq(logic d, logic e, logic md, logic me);
        return (d && !md) || (e && !me);
    endfunction

    function automatic logic [31:0] exp_status(logic t, logic s, int lvl, logic e);
        return (32'(t) << 4) | (32'(s) << 5) | (32'(lvl) << 8) | (32'(e) << 16);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v, w;
        int k, lvl;
        void'($urandom(32'd1234));
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 and R2: reset values and map
        rd(5'h00, v); check("R2 ident", v, 32'h2000_0103);
        rd(5'h04, v); check("R2 cmd reads zero", v, 32'h0);
        rd(5'h0C, v); check("R1 status", v, 32'h0);
        rd(5'h10, v); check("R1 error word", v, 32'h0);
        rd(5'h08, v); check("R1 control", v, 32'h60);
        check("R1 irq", 32'(irq), 32'h0);
        // R5: empty queue read
        rd(5'h14, v); check("R5 empty read", v, 32'h0);
        rd(5'h0C, v); check("R5 empty level", v, exp_status(0, 0, 0, 0));

        // R3: self-test, seed command while busy ignored
        wr(5'h08, 32'h0);
        wr(5'h04, 32'h1);
        wr(5'h04, 32'h2);
        idle(OPC + 4);
        rd(5'h0C, v); check("R3 test done, busy seed dropped", v, exp_status(1, 0, 0, 0));
        check("R7 irq on done", 32'(irq), 32'(exp_irq(1, 0, 0, 0)));
        // R9: clear-interrupt with no error
        wr(5'h04, 32'h10);
        rd(5'h0C, v); check("R9 clear done", v, 32'h0);
        check("R9 irq low", 32'(irq), 32'h0);

        // R4: seed then fill
        wr(5'h04, 32'h2);
        idle(OPC + 24);
        rd(5'h0C, v); check("R4 seeded and full", v, exp_status(0, 1, 16, 0));

        // R6: popped words
        rd(5'h14, v);
        rd(5'h14, w);
        check("R6 word nonzero", 32'(v != 0), 32'h1);
        check("R6 words differ", 32'(v != w), 32'h1);

        // R7: random masks
        for (int i = 0; i < 8; i++) begin
            logic md, me;
            md = 1'($urandom); me = 1'($urandom);
            wr(5'h08, {25'd0, me, md, 5'd0});
            idle(1);
            check("R7 irq vs masks", 32'(irq), 32'(exp_irq(1, 0, md, me)));
        end

        // R8: injected error freezes refill
        wr(5'h08, 32'h0);
        wr(5'h04, 32'h10);
        idle(4);
        inject_err = 1'b1;
        wr(5'h04, 32'h1);
        idle(OPC + 4);
        inject_err = 1'b0;
        rd(5'h0C, v); check("R8 status error", v, exp_status(1, 0, 16, 1));
        rd(5'h10, v); check("R8 error word", v, 32'h8);
        check("R7 irq on error", 32'(irq), 32'h1);
        k = 1 + int'($urandom % 20);
        lvl = 16;
        for (int i = 0; i < k; i++) begin
            rd(5'h14, v);
            if (lvl == 0) check("R5 empty read returns zero", v, 32'h0);
            else begin
                check("R6 popped word nonzero", 32'(v != 0), 32'h1);
                lvl--;
            end
        end
        idle(5);
        rd(5'h0C, v); check("R5/R8 level after random drain", v, exp_status(1, 0, lvl, 1));

        // R9: clear-interrupt blocked
        wr(5'h04, 32'h10);
        rd(5'h0C, v); check("R9 blocked by error", v, exp_status(1, 0, lvl, 1));
        wr(5'h08, 32'h60);
        idle(1);
        check("R7 fully masked", 32'(irq), 32'h0);

        // R10: clear-error
        wr(5'h04, 32'h20);
        rd(5'h0C, v); check("R10 flags cleared", {v[31:13], 8'd0, v[7:0]} , 32'h0);
        rd(5'h10, v); check("R10 error word cleared", v, 32'h0);
        idle(24);
        rd(5'h0C, v); check("R10 refill resumes", v, exp_status(0, 0, 16, 0));

        // R11: automatic reseed at the threshold
        wr(5'h08, 32'h10);
        for (int i = 0; i < RSW - 1; i++) rd(5'h14, v);
        idle(OPC + 4);
        rd(5'h0C, v); check("R11 no reseed before threshold", 32'(v[5]), 32'h0);
        rd(5'h14, v);
        idle(OPC + 4);
        rd(5'h0C, v); check("R11 reseed at threshold", 32'(v[5]), 32'h1);
        check("R11 irq on auto seed", 32'(irq), 32'h1);
        wr(5'h04, 32'h10);
        wr(5'h08, 32'h0);
        for (int i = 0; i < RSW + 5; i++) rd(5'h14, v);
        idle(OPC + 4);
        rd(5'h0C, v); check("R11 disabled no reseed", 32'(v[5]), 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule